// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block does integer multiplication and division for a 16-bit CPU that works on registers. One start pulse delivers an opcode and two operands. The unit then works through one shift step per clock on an upper-word and lower-word register pair. A small loop counter sets how many steps run. A final cycle fixes the signs and loads the result registers, and a one-cycle done pulse marks the result as ready.

Multiplies come in two sizes. A word multiply takes two 16-bit operands and gives a 32-bit product. A byte multiply takes two 8-bit operands and gives a 16-bit product. Divides also come in two sizes. A word divide takes a 32-bit dividend and a 16-bit divisor. A byte divide takes a 16-bit dividend and an 8-bit divisor. Both divides return a quotient and a remainder. Every form has a signed and an unsigned opcode. Signed forms run on magnitudes, and the signs are applied at the end.

Multiply adds the second operand into the upper word and shifts right. Divide shifts left and tries a subtraction, which is an addition with the divisor complemented. One 17-bit adder serves both.

Top module: `iter_muldiv`

## Requirements
- R1: The opcode bits are decoded as follows. Bit 2 selects divide (1) or multiply (0). Bit 1 selects the byte size (1) or the word size (0). Bit 0 selects signed (1) or unsigned (0). Operand A is read from `opa_i[15:0]` for a word multiply, `opa_i[7:0]` for a byte multiply, `opa_i[31:0]` for a word divide and `opa_i[15:0]` for a byte divide. Operand B is read from `opb_i[15:0]` for word forms and `opb_i[7:0]` for byte forms. Input bits outside these fields are ignored.
- R2: A word multiply writes the 32-bit product with its high half in `res_hi_o` and its low half in `res_lo_o`. The product is two's complement for the signed opcode.
- R3: A byte multiply writes the 16-bit product to `res_lo_o` and zero to `res_hi_o`.
- R4: A word divide writes the low 16 bits of the quotient to `res_lo_o` and the remainder to `res_hi_o`. The quotient is truncated toward zero. For the signed opcode the quotient is negative when the operand signs differ, and the remainder takes the sign of the dividend.
- R5: A byte divide writes {remainder[7:0], quotient[7:0]} to `res_lo_o` and zero to `res_hi_o`. It uses the same truncation and sign rules as R4.
- R6: `busy_o` goes high for exactly N+1 cycles after an accepted start. N is 16 for a word multiply, 8 for a byte multiply, 32 for a word divide and 16 for a byte divide. `done_o` is high for exactly one cycle, the cycle right after `busy_o` falls. The result registers take their new values in that same cycle.
- R7: A divide with a zero divisor field makes `done_o` and `div_err_o` high for one cycle, in the cycle after the start. `busy_o` stays low, and the result registers keep their previous values.
- R8: A start pulse while `busy_o` is high is ignored. The running operation finishes with its own timing and result.
- R9: After reset, `busy_o`, `done_o` and `div_err_o` are low and both result outputs are zero.
- R10: The result outputs change only in a cycle where `done_o` is high.
- R11: `div_err_o` is high only while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; taken only when the unit is idle |
| op_i | input | 3 | Opcode: {divide, byte, signed} |
| opa_i | input | 32 | Dividend or first factor |
| opb_i | input | 16 | Divisor or second factor |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide-by-zero indication, high together with done |
| res_hi_o | output | 16 | Upper result word |
| res_lo_o | output | 16 | Lower result word |

## Verification
A wrong loop count or a bad state transition shows up first on `busy_o` and `done_o`. A reference model that runs alongside the design compares both outputs on every clock, so a count that is off by one edge is caught in the cycle where the pulse should appear. A corrupted partial product, remainder or sign flag appears only when the result registers load, in the done cycle. Per-cycle comparison of both result words catches it there. The same comparison flags any change to the result words outside a done cycle, including one after an ignored start or a zero-divisor abort.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int DWORD_W = 2 * WORD_W;
    localparam int ADD_W   = WORD_W + 1;
    localparam int CNT_W   = 6;
    localparam int OP_W    = 3;

    // opcode bit positions
    localparam int OPB_SGN  = 0;
    localparam int OPB_BYTE = 1;
    localparam int OPB_DIV  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } st_e;

    typedef struct packed {
        st_e                st;
        logic [CNT_W-1:0]   cnt;
        logic [OP_W-1:0]    op;
        logic               aneg;
        logic               bneg;
        logic [WORD_W-1:0]  up;
        logic [DWORD_W-1:0] lo;
        logic [WORD_W-1:0]  bv;
        logic [WORD_W-1:0]  rhi;
        logic [WORD_W-1:0]  rlo;
        logic               done;
        logic               err;
    } regs_t;

    function automatic logic [CNT_W-1:0] step_count(input logic [OP_W-1:0] op);
        logic [CNT_W-1:0] n;
        case ({op[OPB_DIV], op[OPB_BYTE]})
            2'b00:   n = CNT_W'(WORD_W);
            2'b01:   n = CNT_W'(BYTE_W);
            2'b10:   n = CNT_W'(DWORD_W);
            default: n = CNT_W'(WORD_W);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/muldiv_add17.sv
module muldiv_add17 #(
    parameter int W = 17
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W:0]   sum_o
);
    always_comb begin
        sum_o = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end
endmodule

// File: rtl/muldiv_sign_prep.sv
module muldiv_sign_prep
    import muldiv_pkg::*;
(
    input  logic [OP_W-1:0]    op_i,
    input  logic [DWORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0]  opb_i,
    output logic [DWORD_W-1:0] a_mag_o,
    output logic [WORD_W-1:0]  b_mag_o,
    output logic               a_neg_o,
    output logic               b_neg_o
);
    logic               sgn;
    logic [DWORD_W-1:0] a_s;
    logic [WORD_W-1:0]  b_s;

    always_comb begin
        sgn = op_i[OPB_SGN];
        case ({op_i[OPB_DIV], op_i[OPB_BYTE]})
            2'b00:   a_s = {{(DWORD_W-WORD_W){sgn & opa_i[WORD_W-1]}}, opa_i[WORD_W-1:0]};
            2'b01:   a_s = {{(DWORD_W-BYTE_W){sgn & opa_i[BYTE_W-1]}}, opa_i[BYTE_W-1:0]};
            2'b10:   a_s = opa_i;
            default: a_s = {{(DWORD_W-WORD_W){sgn & opa_i[WORD_W-1]}}, opa_i[WORD_W-1:0]};
        endcase
        if (op_i[OPB_BYTE]) begin
            b_s = {{(WORD_W-BYTE_W){sgn & opb_i[BYTE_W-1]}}, opb_i[BYTE_W-1:0]};
        end else begin
            b_s = opb_i;
        end
        a_neg_o = sgn & a_s[DWORD_W-1];
        b_neg_o = sgn & b_s[WORD_W-1];
        a_mag_o = a_neg_o ? (~a_s + DWORD_W'(1)) : a_s;
        b_mag_o = b_neg_o ? (~b_s + WORD_W'(1)) : b_s;
    end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step
    import muldiv_pkg::*;
(
    input  logic               is_div_i,
    input  logic [WORD_W-1:0]  up_i,
    input  logic [DWORD_W-1:0] lo_i,
    input  logic [WORD_W-1:0]  bv_i,
    output logic [WORD_W-1:0]  up_o,
    output logic [DWORD_W-1:0] lo_o
);
    logic [ADD_W-1:0] add_a;
    logic [ADD_W-1:0] add_b;
    logic             add_c;
    logic [ADD_W:0]   add_s;
    logic             fits;

    // operand routing: complement the second operand for a trial subtraction
    always_comb begin
        if (is_div_i) begin
            add_a = {up_i, lo_i[DWORD_W-1]};
            add_b = ~{1'b0, bv_i};
            add_c = 1'b1;
        end else begin
            add_a = {1'b0, up_i};
            add_b = lo_i[0] ? {1'b0, bv_i} : '0;
            add_c = 1'b0;
        end
    end

    muldiv_add17 #(.W(ADD_W)) u_add (
        .a_i  (add_a),
        .b_i  (add_b),
        .cin_i(add_c),
        .sum_o(add_s)
    );

    always_comb begin
        fits = add_s[ADD_W];
        if (is_div_i) begin
            up_o = fits ? add_s[WORD_W-1:0] : add_a[WORD_W-1:0];
            lo_o = {lo_i[DWORD_W-2:0], fits};
        end else begin
            up_o = add_s[ADD_W-1:1];
            lo_o = {{(DWORD_W-WORD_W){1'b0}}, add_s[0], lo_i[WORD_W-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_sign_fix.sv
module muldiv_sign_fix
    import muldiv_pkg::*;
(
    input  logic [OP_W-1:0]    op_i,
    input  logic               aneg_i,
    input  logic               bneg_i,
    input  logic [WORD_W-1:0]  up_i,
    input  logic [DWORD_W-1:0] lo_i,
    output logic [WORD_W-1:0]  hi_o,
    output logic [WORD_W-1:0]  lo_o
);
    logic               neg_q;
    logic [DWORD_W-1:0] prod;
    logic [WORD_W-1:0]  p16;
    logic [WORD_W-1:0]  quo;
    logic [WORD_W-1:0]  rem;

    always_comb begin
        neg_q = aneg_i ^ bneg_i;
        prod  = {up_i, lo_i[WORD_W-1:0]};
        p16   = up_i;
        quo   = lo_i[WORD_W-1:0];
        rem   = up_i;
        if (neg_q) begin
            prod = ~prod + DWORD_W'(1);
            p16  = ~p16 + WORD_W'(1);
            quo  = ~quo + WORD_W'(1);
        end
        if (aneg_i) begin
            rem = ~rem + WORD_W'(1);
        end
        case ({op_i[OPB_DIV], op_i[OPB_BYTE]})
            2'b00: begin
                hi_o = prod[DWORD_W-1:WORD_W];
                lo_o = prod[WORD_W-1:0];
            end
            2'b01: begin
                hi_o = '0;
                lo_o = p16;
            end
            2'b10: begin
                hi_o = rem;
                lo_o = quo;
            end
            default: begin
                hi_o = '0;
                lo_o = {rem[BYTE_W-1:0], quo[BYTE_W-1:0]};
            end
        endcase
    end
endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
    import muldiv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [DWORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0]  opb_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               div_err_o,
    output logic [WORD_W-1:0]  res_hi_o,
    output logic [WORD_W-1:0]  res_lo_o
);
    regs_t r_q, r_d;

    logic [DWORD_W-1:0] a_mag;
    logic [WORD_W-1:0]  b_mag;
    logic               a_neg, b_neg;
    logic [WORD_W-1:0]  step_up;
    logic [DWORD_W-1:0] step_lo;
    logic [WORD_W-1:0]  fix_hi, fix_lo;

    muldiv_sign_prep u_prep (
        .op_i   (op_i),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .a_mag_o(a_mag),
        .b_mag_o(b_mag),
        .a_neg_o(a_neg),
        .b_neg_o(b_neg)
    );

    muldiv_step u_step (
        .is_div_i(r_q.op[OPB_DIV]),
        .up_i    (r_q.up),
        .lo_i    (r_q.lo),
        .bv_i    (r_q.bv),
        .up_o    (step_up),
        .lo_o    (step_lo)
    );

    muldiv_sign_fix u_fix (
        .op_i  (r_q.op),
        .aneg_i(r_q.aneg),
        .bneg_i(r_q.bneg),
        .up_i  (r_q.up),
        .lo_i  (r_q.lo),
        .hi_o  (fix_hi),
        .lo_o  (fix_lo)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (op_i[OPB_DIV] && (b_mag == '0)) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.st   = ST_RUN;
                        r_d.op   = op_i;
                        r_d.aneg = a_neg;
                        r_d.bneg = b_neg;
                        r_d.cnt  = step_count(op_i);
                        r_d.up   = '0;
                        r_d.bv   = b_mag;
                        case ({op_i[OPB_DIV], op_i[OPB_BYTE]})
                            2'b00: r_d.lo = {{(DWORD_W-WORD_W){1'b0}}, a_mag[WORD_W-1:0]};
                            2'b01: begin
                                r_d.lo = {{(DWORD_W-BYTE_W){1'b0}}, a_mag[BYTE_W-1:0]};
                                r_d.bv = {b_mag[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
                            end
                            2'b10: r_d.lo = a_mag;
                            default: r_d.lo = {a_mag[WORD_W-1:0], {(DWORD_W-WORD_W){1'b0}}};
                        endcase
                    end
                end
            end
            ST_RUN: begin
                r_d.up  = step_up;
                r_d.lo  = step_lo;
                r_d.cnt = r_q.cnt - CNT_W'(1);
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.rhi  = fix_hi;
                r_d.rlo  = fix_lo;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign div_err_o = r_q.err;
    assign res_hi_o  = r_q.rhi;
    assign res_lo_o  = r_q.rlo;

    assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_follows_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_err_o) |-> $past(busy_o));

    assert_run_count_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_RUN) |-> (r_q.cnt != '0));

    assert_zero_div_no_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_err_o |-> !busy_o);

    assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(r_q.op));

    assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable({res_hi_o, res_lo_o}));

    assert_err_with_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_err_o |-> done_o);

endmodule

// File: tb/iter_muldiv_bench.sv
module iter_muldiv_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opa = '0;
    logic [15:0] opb = '0;
    logic        busy, done, derr;
    logic [15:0] rhi, rlo;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 0;
    bit    finished = 0;
    string cur_tag = "R9 reset";

    // reference model state
    int          m_cnt = 0;
    bit          m_done = 0;
    bit          m_err = 0;
    logic [15:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iter_muldiv u_iter_muldiv (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .op_i     (op),
        .opa_i    (opa),
        .opb_i    (opb),
        .busy_o   (busy),
        .done_o   (done),
        .div_err_o(derr),
        .res_hi_o (rhi),
        .res_lo_o (rlo)
    );

    // R6: step counts per operation class
    function automatic int steps(input logic [2:0] o);
        case (o[2:1])
            2'b00:   return 16;
            2'b01:   return 8;
            2'b10:   return 32;
            default: return 16;
        endcase
    endfunction

    // R1..R5 arithmetic, computed with wide integers
    function automatic void ref_calc(input logic [2:0] o, input logic [31:0] a,
                                     input logic [15:0] b, output logic [15:0] hi,
                                     output logic [15:0] lo, output bit zero);
        longint n, d, q, r;
        logic [63:0] pv, qv, rv;
        zero = 0; hi = '0; lo = '0;
        case (o[2:1])
            2'b00: begin
                n  = o[0] ? longint'($signed(a[15:0])) : longint'(a[15:0]);
                d  = o[0] ? longint'($signed(b[15:0])) : longint'(b[15:0]);
                pv = n * d;
                hi = pv[31:16]; lo = pv[15:0];
            end
            2'b01: begin
                n  = o[0] ? longint'($signed(a[7:0])) : longint'(a[7:0]);
                d  = o[0] ? longint'($signed(b[7:0])) : longint'(b[7:0]);
                pv = n * d;
                lo = pv[15:0];
            end
            2'b10: begin
                n = o[0] ? longint'($signed(a)) : longint'(a);
                d = o[0] ? longint'($signed(b[15:0])) : longint'(b[15:0]);
                if (d == 0) zero = 1;
                else begin
                    q = n / d; r = n % d; qv = q; rv = r;
                    lo = qv[15:0]; hi = rv[15:0];
                end
            end
            default: begin
                n = o[0] ? longint'($signed(a[15:0])) : longint'(a[15:0]);
                d = o[0] ? longint'($signed(b[7:0])) : longint'(b[7:0]);
                if (d == 0) zero = 1;
                else begin
                    q = n / d; r = n % d; qv = q; rv = r;
                    lo = {rv[7:0], qv[7:0]};
                end
            end
        endcase
    endfunction

    always @(posedge clk) begin
        logic [15:0] th, tl;
        bit z;
        started = 1;
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_err = 0; m_hi = '0; m_lo = '0;
        end else begin
            m_done = 0; m_err = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_hi = p_hi; m_lo = p_lo;
                end
            end else if (start) begin
                ref_calc(op, opa, opb, th, tl, z);
                if (z) begin
                    m_done = 1; m_err = 1;
                end else begin
                    p_hi = th; p_lo = tl; m_cnt = steps(op) + 1;
                end
            end
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R6 busy", 32'(busy), 32'(m_cnt > 0));
            chk("R6 done pulse", 32'(done), 32'(m_done));
            chk("R7/R11 div_err", 32'(derr), 32'(m_err));
            chk({cur_tag, " res_hi (R10 hold)"}, 32'(rhi), 32'(m_hi));
            chk({cur_tag, " res_lo (R10 hold)"}, 32'(rlo), 32'(m_lo));
        end
    end

    task automatic run_op(input logic [2:0] o, input logic [31:0] a,
                          input logic [15:0] b, input string t);
        @(negedge clk);
        cur_tag = t;
        op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1/R2 word multiply (op 000 unsigned, 001 signed)
        run_op(3'b000, 32'h0000_FFFF, 16'hFFFF, "R1/R2 mulu max");
        run_op(3'b001, 32'h0000_8000, 16'h8000, "R2 mul min*min");
        run_op(3'b001, 32'hDEAD_FFFF, 16'h0005, "R1/R2 mul -1*5 upper opa ignored");
        run_op(3'b001, 32'h0000_7FFF, 16'h8000, "R2 mul max*min");
        // R3 byte multiply (010 unsigned, 011 signed)
        run_op(3'b010, 32'hABCD_12FF, 16'h77FF, "R1/R3 mulub ignored bits");
        run_op(3'b011, 32'h0000_0080, 16'h0080, "R3 mulb -128*-128");
        run_op(3'b011, 32'h0000_00FF, 16'h0003, "R3 mulb -1*3");
        // R4 word divide (100 unsigned, 101 signed)
        run_op(3'b100, 32'hFFFF_FFFF, 16'h0001, "R4 divu truncated quotient");
        run_op(3'b100, 32'd100, 16'd7, "R4 divu 100/7");
        run_op(3'b101, -32'sd100, 16'd7, "R4 div -100/7");
        run_op(3'b101, 32'd100, -16'sd7, "R4 div 100/-7");
        run_op(3'b101, 32'h8000_0000, 16'h8000, "R4 div min/min");
        run_op(3'b100, 32'h1234_5678, 16'hFFFF, "R4 divu large divisor");
        // R5 byte divide (110 unsigned, 111 signed)
        run_op(3'b110, 32'h0000_FFFF, 16'h00FF, "R5 divub");
        run_op(3'b111, 32'h0000_FF9C, 16'h5507, "R1/R5 divb -100/7");
        run_op(3'b111, 32'h0000_8000, 16'h00FF, "R5 divb min/-1");
        // R7 zero divisor
        run_op(3'b100, 32'h0000_1234, 16'h0000, "R7 divu by zero");
        run_op(3'b111, 32'h0000_1234, 16'h1200, "R7 divb zero low byte");

        // R8 start while busy, mid-run and in the final busy cycle
        @(negedge clk);
        cur_tag = "R8 ignored start";
        op = 3'b000; opa = 32'h0000_1234; opb = 16'h0101; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op = 3'b101; opa = 32'h0000_0009; opb = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt != 1) @(negedge clk);
        op = 3'b010; opa = 32'h0000_0011; opb = 16'h0011; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);

        // R2..R5 mixed patterns
        for (int k = 0; k < 80; k++) begin
            logic [2:0] o;
            o = 3'(k % 8);
            run_op(o, $urandom, 16'($urandom), "R2-5 pattern");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule